// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider Chain

This block produces the master clock and the serial bit clock for one direction of an audio serial port, starting from the source clock it runs on. In normal operation the source passes through a prescaler that divides by 1 or 8, then a programmable divider with ratios 1 to 256, then a fixed divide-by-2 stage that forms the master clock. A last divider with ratios 1 to 16 counts master clock cycles to form the bit clock. Software picks the ratios and writes them over a small write port. The block does not search for divisors.

Three operating modes follow from the control register. CHAIN drives the master clock pin from the divider chain. BYPASS is valid only when the source is marked as the external crystal. It sends the source straight to the master clock pin, skips every upper divider, and feeds the bit clock divider one tick per source cycle. EXTIN turns the master clock pin into an input and stops the upper dividers. The pin is synchronised, and its rising edges advance the bit clock divider. Each clock output is a registered phase machine with the states PH_LOW and PH_HIGH. A phase machine moves PH_LOW to PH_HIGH at the start of a period and PH_HIGH to PH_LOW when its high count runs out. Divider fields written in mid-count are taken up only at the divider's next terminal count.

Top module: `audclk_divchain`

## Requirements
- R1: A synchronous reset clears all counters and configuration fields. While reset is held and on the first cycle after it, mclk_o, mclk_oe and bclk_o are all 0.
- R2: Writes use wr_addr 0 for control, 1 for the master divider field and 2 for the bit divider field. The control bits are: bit0 selects the divide-by-8 prescaler, bit1 makes the master pin an output, bit2 requests bypass, and bit3 marks the source as external. A write to wr_addr 3 changes nothing.
- R3: In CHAIN mode (bit1=1 and no valid bypass), the master clock period is 2*P*(M+1) source cycles with a high phase of P*(M+1). M is the master field, and P is 1, or 8 when bit0 is set.
- R4: Setting control bit0 multiplies the master clock period by 8.
- R5: The master field covers every ratio from 1 (field 0) to 256 (field 255).
- R6: The bit clock ratio is F+1 master cycles, where F is the low 4 bits of the bit field. For a ratio r>1 the high phase lasts ceil(r/2) master cycles and the low phase lasts floor(r/2), so even ratios give 50% duty.
- R7: With F=0, bclk_o follows the master clock reference directly.
- R8: When bit1, bit2 and bit3 are all set (BYPASS), mclk_o equals the source clock, mclk_oe is 1, and the bit clock divides the source by F+1.
- R9: A bypass request without bit3 is ignored and the block stays in CHAIN mode.
- R10: With bit1=0 (EXTIN), mclk_oe and mclk_o are 0. The bit clock divides the synchronised rising edges of mclk_pin_i by F+1.
- R11: A master or bit field write takes effect only at that divider's next terminal count, so the phase in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; all logic runs on it |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration register select |
| wr_data | input | 8 | Configuration write data |
| mclk_pin_i | input | 1 | Master clock arriving at the pin in EXTIN mode |
| mclk_o | output | 1 | Master clock driven to the pin |
| mclk_oe | output | 1 | Master pin output enable |
| bclk_o | output | 1 | Serial bit clock |

## Verification
The bench looks for internal faults in the waveforms at the clock ports. A wrong prescaler or master counter value shows up in the next measured master clock phase, within at most 2048 source cycles. A wrong bit-divider phase state or count shows up as a wrong high or low run on bclk_o within one bit clock period. A field that is latched too early shows up in the same half period as the write: the phase in progress comes out shorter than it should. A wrong mode decode shows at once on mclk_oe or as a master clock that stays idle.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
package audclk_pkg;
    typedef enum logic [1:0] {
        MODE_EXTIN  = 2'd0,
        MODE_CHAIN  = 2'd1,
        MODE_BYPASS = 2'd2
    } clk_mode_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic src_ext;
        logic bypass;
        logic dir_out;
        logic pre8;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MDIV = 2'd1;
    localparam logic [1:0] ADDR_BDIV = 2'd2;
endpackage

// File: rtl/audclk_cfg.sv
`timescale 1ns/1ps
module audclk_cfg
    import audclk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PM_W   = 8,
    parameter int FP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [PM_W-1:0]   pm_field,
    output logic [FP_W-1:0]   fp_field,
    output clk_mode_e         mode
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            pm_field <= '0;
            fp_field <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: ctrl     <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_MDIV: pm_field <= wr_data[PM_W-1:0];
                ADDR_BDIV: fp_field <= wr_data[FP_W-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        if (!ctrl.dir_out)
            mode = MODE_EXTIN;
        else if (ctrl.bypass && ctrl.src_ext)
            mode = MODE_BYPASS;
        else
            mode = MODE_CHAIN;
    end

    // R2
    spare_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd3) |=> ($stable(ctrl) && $stable(pm_field) && $stable(fp_field)));
endmodule

// File: rtl/audclk_sync.sv
`timescale 1ns/1ps
module audclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES:0] pipe;
    logic            prev_q;

    assign pipe[0] = pin_i;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i+1] <= 1'b0;
            else     pipe[i+1] <= pipe[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pipe[STAGES];
    end

    assign level_o = pipe[STAGES];
    assign rise_o  = pipe[STAGES] & ~prev_q;
endmodule

// File: rtl/audclk_upper.sv
`timescale 1ns/1ps
module audclk_upper
    import audclk_pkg::*;
#(
    parameter int PM_W      = 8,
    parameter int PRE_RATIO = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            pre8,
    input  logic [PM_W-1:0] pm_field,
    output logic            mclk_q,
    output logic            rise_tick
);
    localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

    logic            pre_tick;
    logic            pm_tick;
    logic [PM_W-1:0] pm_cnt, pm_cnt_n;
    phase_e          st, st_n;

    if (PRE_RATIO > 1) begin : g_pre
        logic [PRE_W-1:0] pre_cnt, pre_cnt_n;
        always_comb begin
            pre_tick = en && (!pre8 || pre_cnt == '0);
            if (en && pre8)
                pre_cnt_n = (pre_cnt == '0) ? PRE_W'(PRE_RATIO - 1) : pre_cnt - 1'b1;
            else
                pre_cnt_n = '0;
        end
        always_ff @(posedge clk) begin
            if (rst) pre_cnt <= '0;
            else     pre_cnt <= pre_cnt_n;
        end
    end else begin : g_nopre
        logic unused_pre;
        assign unused_pre = pre8;
        assign pre_tick   = en;
    end

    always_comb begin
        pm_tick  = 1'b0;
        pm_cnt_n = pm_cnt;
        if (pre_tick) begin
            if (pm_cnt == '0) begin
                pm_tick  = 1'b1;
                pm_cnt_n = pm_field;
            end else begin
                pm_cnt_n = pm_cnt - 1'b1;
            end
        end
    end

    always_comb begin
        st_n = st;
        if (pm_tick) begin
            unique case (st)
                PH_LOW:  st_n = PH_HIGH;
                PH_HIGH: st_n = PH_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pm_cnt <= '0;
            st     <= PH_LOW;
        end else begin
            pm_cnt <= pm_cnt_n;
            st     <= st_n;
        end
    end

    always_comb begin
        mclk_q    = (st == PH_HIGH);
        rise_tick = pm_tick && (st == PH_LOW);
    end

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mclk_q);

    // R3
    toggle_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mclk_q) && $past(en)) |-> $past(pre_tick));
endmodule

// File: rtl/audclk_lower.sv
`timescale 1ns/1ps
module audclk_lower
    import audclk_pkg::*;
#(
    parameter int FP_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [FP_W-1:0] fp_field,
    input  logic            ref_lvl,
    output logic            bclk_o
);
    logic [FP_W-1:0] fp_act, fp_act_n;
    logic [FP_W-1:0] cnt, cnt_n;
    logic [FP_W:0]   ratio_act;
    phase_e          st, st_n;

    assign ratio_act = {1'b0, fp_act} + 1'b1;

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        fp_act_n = fp_act;
        if (tick) begin
            unique case (st)
                PH_LOW: begin
                    if (cnt == '0 || fp_act == '0) begin
                        fp_act_n = fp_field;
                        st_n     = PH_HIGH;
                        cnt_n    = fp_field >> 1;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (fp_act == '0) begin
                        fp_act_n = fp_field;
                        cnt_n    = fp_field >> 1;
                    end else if (cnt == '0) begin
                        st_n  = PH_LOW;
                        cnt_n = FP_W'((ratio_act >> 1) - 1'b1);
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PH_LOW;
            cnt    <= '0;
            fp_act <= '0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            fp_act <= fp_act_n;
        end
    end

    always_comb begin
        if (fp_act == '0) bclk_o = ref_lvl;
        else              bclk_o = (st == PH_HIGH);
    end

    // R11
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(fp_act));

    // R6
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st == PH_HIGH) |-> $past(tick));
endmodule

// File: rtl/audclk_divchain.sv
`timescale 1ns/1ps
module audclk_divchain
    import audclk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PM_W        = 8,
    parameter int FP_W        = 4,
    parameter int PRE_RATIO   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mclk_pin_i,
    output logic              mclk_o,
    output logic              mclk_oe,
    output logic              bclk_o
);
    ctrl_t           ctrl;
    clk_mode_e       mode;
    logic [PM_W-1:0] pm_field;
    logic [FP_W-1:0] fp_field;
    logic            chain_en;
    logic            mclk_div, div_rise;
    logic            pin_lvl, pin_rise;
    logic            low_tick, ref_lvl;

    audclk_cfg #(.DATA_W(DATA_W), .PM_W(PM_W), .FP_W(FP_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl), .pm_field(pm_field), .fp_field(fp_field), .mode(mode)
    );

    assign chain_en = (mode == MODE_CHAIN);

    audclk_upper #(.PM_W(PM_W), .PRE_RATIO(PRE_RATIO)) u_upper (
        .clk(clk), .rst(rst), .en(chain_en), .pre8(ctrl.pre8), .pm_field(pm_field),
        .mclk_q(mclk_div), .rise_tick(div_rise)
    );

    audclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(mclk_pin_i), .level_o(pin_lvl), .rise_o(pin_rise)
    );

    always_comb begin
        unique case (mode)
            MODE_BYPASS: begin
                mclk_o   = clk;
                mclk_oe  = 1'b1;
                low_tick = 1'b1;
                ref_lvl  = clk;
            end
            MODE_CHAIN: begin
                mclk_o   = mclk_div;
                mclk_oe  = 1'b1;
                low_tick = div_rise;
                ref_lvl  = mclk_div;
            end
            default: begin
                mclk_o   = 1'b0;
                mclk_oe  = 1'b0;
                low_tick = pin_rise;
                ref_lvl  = pin_lvl;
            end
        endcase
    end

    audclk_lower #(.FP_W(FP_W)) u_lower (
        .clk(clk), .rst(rst), .tick(low_tick), .fp_field(fp_field),
        .ref_lvl(ref_lvl), .bclk_o(bclk_o)
    );

    // R10
    pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mclk_oe |-> !mclk_o);
endmodule

// File: tb/test_audclk_divchain.sv
`timescale 1ns/1ps
module test_audclk_divchain;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       mclk_pin_i = 1'b0;
    logic       mclk_o, mclk_oe, bclk_o;
    logic       pin_run = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    audclk_divchain i_audclk_divchain (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mclk_pin_i(mclk_pin_i), .mclk_o(mclk_o), .mclk_oe(mclk_oe), .bclk_o(bclk_o)
    );

    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (pin_run) begin
                cnt++;
                if (cnt == 5) begin
                    mclk_pin_i = ~mclk_pin_i;
                    cnt = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic pick(input int which);
        return (which == 0) ? mclk_o : bclk_o;
    endfunction

    task automatic measure(input int which, output int hi, output int lo);
        int guard;
        hi = 0; lo = 0; guard = 0;
        @(negedge clk);
        while (pick(which) == 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
        while (pick(which) == 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        while (pick(which) == 1'b1 && guard < 5000) begin hi++; @(negedge clk); guard++; end
        while (pick(which) == 1'b0 && guard < 5000) begin lo++; @(negedge clk); guard++; end
        if (guard >= 5000) begin hi = -1; lo = -1; end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 mclk_o in reset", mclk_o, 0);
        check("R1 bclk_o in reset", bclk_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mclk_o after reset", mclk_o, 0);
        check("R1 mclk_oe after reset", mclk_oe, 0);
        check("R1 bclk_o after reset", bclk_o, 0);
    endtask

    task automatic t_chain_basic();
        int hi, lo;
        cfg_write(2'd0, 8'h02);
        cfg_write(2'd1, 8'd2);
        cfg_write(2'd2, 8'd0);
        measure(0, hi, lo);
        check("R3 mclk high M=3", hi, 3);
        check("R3 mclk low M=3", lo, 3);
        check("R3 mclk_oe chain", mclk_oe, 1);
        cfg_write(2'd3, 8'hFF);
        measure(0, hi, lo);
        check("R2 spare address ignored, high", hi, 3);
        check("R2 spare address ignored, low", lo, 3);
    endtask

    task automatic t_prescale();
        int hi, lo;
        cfg_write(2'd0, 8'h03);
        cfg_write(2'd1, 8'd1);
        measure(0, hi, lo);
        check("R4 prescale8 high", hi, 16);
        check("R4 prescale8 low", lo, 16);
    endtask

    task automatic t_pm_max();
        int hi, lo;
        cfg_write(2'd0, 8'h02);
        cfg_write(2'd1, 8'd255);
        measure(0, hi, lo);
        check("R5 ratio 256 high", hi, 256);
        check("R5 ratio 256 low", lo, 256);
    endtask

    task automatic t_bit_divider();
        int hi, lo;
        cfg_write(2'd0, 8'h02);
        cfg_write(2'd1, 8'd0);
        cfg_write(2'd2, 8'd3);
        measure(1, hi, lo);
        check("R6 bclk ratio 4 high", hi, 4);
        check("R6 bclk ratio 4 low", lo, 4);
        cfg_write(2'd2, 8'd2);
        measure(1, hi, lo);
        check("R6 bclk ratio 3 high", hi, 4);
        check("R6 bclk ratio 3 low", lo, 2);
        cfg_write(2'd2, 8'd15);
        measure(1, hi, lo);
        check("R6 bclk ratio 16 high", hi, 16);
        check("R6 bclk ratio 16 low", lo, 16);
        cfg_write(2'd2, 8'd0);
        measure(1, hi, lo);
        check("R7 bclk ratio 1 high", hi, 1);
        check("R7 bclk ratio 1 low", lo, 1);
    endtask

    task automatic t_bypass();
        int hi, lo;
        cfg_write(2'd0, 8'h0E);
        cfg_write(2'd2, 8'd2);
        @(posedge clk); #1;
        check("R8 bypass mclk high with source", mclk_o, 1);
        @(negedge clk); #1;
        check("R8 bypass mclk low with source", mclk_o, 0);
        check("R8 bypass mclk_oe", mclk_oe, 1);
        measure(1, hi, lo);
        check("R8 bypass bclk ratio 3 high", hi, 2);
        check("R8 bypass bclk ratio 3 low", lo, 1);
    endtask

    task automatic t_bypass_no_ext();
        int hi, lo;
        cfg_write(2'd1, 8'd1);
        cfg_write(2'd0, 8'h06);
        measure(0, hi, lo);
        check("R9 bypass without ext stays chain, high", hi, 2);
        check("R9 bypass without ext stays chain, low", lo, 2);
    endtask

    task automatic t_extin();
        int hi, lo;
        int bad;
        cfg_write(2'd0, 8'h00);
        cfg_write(2'd2, 8'd1);
        pin_run = 1'b1;
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (mclk_o !== 1'b0 || mclk_oe !== 1'b0) bad++;
        end
        check("R10 master pin quiet as input", bad, 0);
        measure(1, hi, lo);
        check("R10 bclk from pin high", hi, 10);
        check("R10 bclk from pin low", lo, 10);
        pin_run = 1'b0;
    endtask

    task automatic t_deferred();
        int hi, lo, guard;
        cfg_write(2'd0, 8'h02);
        cfg_write(2'd1, 8'd9);
        measure(0, hi, lo);
        guard = 0;
        while (mclk_o == 1'b1 && guard < 100) begin @(negedge clk); guard++; end
        while (mclk_o == 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        hi = 1;
        @(negedge clk);
        if (mclk_o) hi++;
        @(negedge clk);
        if (mclk_o) hi++;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd1;
        @(negedge clk);
        wr_en = 1'b0;
        if (mclk_o) hi++;
        guard = 0;
        while (mclk_o == 1'b1 && guard < 100) begin @(negedge clk); if (mclk_o) hi++; guard++; end
        lo = 0;
        while (mclk_o == 1'b0 && guard < 200) begin lo++; @(negedge clk); guard++; end
        check("R11 phase in progress keeps old length", hi, 10);
        check("R11 next phase uses new field", lo, 2);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_chain_basic();
        t_prescale();
        t_pm_max();
        t_bit_divider();
        t_bypass();
        t_bypass_no_ext();
        t_extin();
        t_deferred();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule